// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block sits beside the instruction fetch address register and guesses, in the same cycle the fetch PC is presented, where fetch should go next. It is a direct-mapped table of branch records. Each record holds a valid bit, a tag, the target address the branch reached the last time it resolved, and a four-state saturating direction counter. Any lookup that matches a record marks the fetched word as a branch. The counter then chooses between the stored target and the sequential address. A lookup that matches nothing predicts the sequential address.

Resolved branches come back from execute on the update port, carrying the branch PC, the actual direction and the computed target. A matching record has its counter moved one step toward the outcome and its target replaced. A taken branch with no record claims the slot at its index, evicting whatever was there. A not-taken branch with no record leaves the table alone.

Each record's counter is a small state machine with four states: STRONG_NT (code 0), WEAK_NT (code 1), WEAK_T (code 2) and STRONG_T (code 3). On a taken outcome it moves STRONG_NT to WEAK_NT, WEAK_NT to WEAK_T, WEAK_T to STRONG_T, and STRONG_T holds. On a not-taken outcome it moves STRONG_T to WEAK_T, WEAK_T to WEAK_NT, WEAK_NT to STRONG_NT, and STRONG_NT holds. A new record starts in WEAK_T.

Top module: `fetch_branch_predictor`

## Requirements
- R1: pred_branch is 1 exactly when the record at index fetch_pc[IDX_W+1:2] is valid and its tag equals fetch_pc[ADDR_W-1:IDX_W+2].
- R2: When pred_branch is 0, pred_taken is 0 and pred_next_pc equals fetch_pc + 4.
- R3: When pred_branch is 1, pred_taken is 1 exactly when the record's counter is WEAK_T (2) or STRONG_T (3). pred_next_pc is the stored target when pred_taken is 1 and fetch_pc + 4 otherwise.
- R4: An update that matches a record moves its counter one step, up on taken and down on not-taken, using codes STRONG_NT=0, WEAK_NT=1, WEAK_T=2, STRONG_T=3. The counter holds at 3 on taken and at 0 on not-taken.
- R5: An update that matches a record replaces the stored target with upd_target, in both directions.
- R6: A taken update that matches no record writes the record at its index as valid, with the update's tag, upd_target, and counter WEAK_T. This replaces any record previously at that index.
- R7: A not-taken update that matches no record changes no record.
- R8: While rst_n is low at a clock edge, every record is made invalid.
- R9: An update takes effect at the clock edge where upd_valid is sampled high. A lookup in that same cycle sees the contents from before the update.
- R10: Bits [1:0] of fetch_pc and upd_pc play no part in indexing or tag matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | ADDR_W | Address being fetched this cycle |
| pred_branch | output | 1 | Fetched word has a record (known branch) |
| pred_taken | output | 1 | Predicted direction is taken |
| pred_next_pc | output | ADDR_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_target | input | ADDR_W | Computed target of the resolved branch |

## Verification
The bench runs long update streams drawn from a small pool of addresses. Several tags share each index, so eviction and aliasing happen often, and every lookup is compared with an arithmetic model of the table.

Several corner cases get targeted checks:
- Saturation at both counter ends. A design that wraps would flip a strongly-biased branch on one extra outcome.
- A not-taken miss. A design that allocates on it would suddenly report a non-branch as a branch.
- A same-index, different-tag lookup. A design with a short tag compare would return a stranger's target.
- Low address bits. A design that indexes with them would miss a branch fetched at an unaligned offset.
- An update and a lookup of the same PC in one cycle. A design with a write-through read would predict early.

// File: rtl/btbp_pkg.sv
package btbp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } dir_state_t;

    function automatic logic dir_says_taken(input dir_state_t s);
        logic r;
        unique case (s)
            CTR_STRONG_NT,
            CTR_WEAK_NT:   r = 1'b0;
            CTR_WEAK_T,
            CTR_STRONG_T:  r = 1'b1;
            default:       r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/btbp_dir_counter.sv
module btbp_dir_counter
    import btbp_pkg::*;
(
    input  dir_state_t cur_state,
    input  logic       outcome_taken,
    output dir_state_t next_state
);

    always_comb begin
        next_state = cur_state;
        unique case (cur_state)
            CTR_STRONG_NT: next_state = outcome_taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   next_state = outcome_taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    next_state = outcome_taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  next_state = outcome_taken ? CTR_STRONG_T : CTR_WEAK_T;
            default:       next_state = CTR_WEAK_T;
        endcase
    end

endmodule

// File: rtl/btbp_entry_array.sv
module btbp_entry_array
    import btbp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = ADDR_W - IDX_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    // read port for the fetch lookup
    input  logic [IDX_W-1:0]  fa_idx,
    output logic              fa_valid,
    output logic [TAG_W-1:0]  fa_tag,
    output logic [ADDR_W-1:0] fa_target,
    output dir_state_t        fa_state,
    // read port for the update path
    input  logic [IDX_W-1:0]  ub_idx,
    output logic              ub_valid,
    output logic [TAG_W-1:0]  ub_tag,
    output dir_state_t        ub_state,
    // write port
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_target,
    input  dir_state_t        wr_state
);

    localparam int DEPTH = 1 << IDX_W;

    logic              valid_q  [DEPTH];
    logic [TAG_W-1:0]  tag_q    [DEPTH];
    logic [ADDR_W-1:0] target_q [DEPTH];
    dir_state_t        state_q  [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[e] <= 1'b0;
            end else if (sel) begin
                valid_q[e] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[e]    <= wr_tag;
                target_q[e] <= wr_target;
                state_q[e]  <= wr_state;
            end
        end
    end

    always_comb begin
        fa_valid  = valid_q[fa_idx];
        fa_tag    = tag_q[fa_idx];
        fa_target = target_q[fa_idx];
        fa_state  = state_q[fa_idx];
        ub_valid  = valid_q[ub_idx];
        ub_tag    = tag_q[ub_idx];
        ub_state  = state_q[ub_idx];
    end

endmodule

// File: rtl/btbp_lookup.sv
module btbp_lookup
    import btbp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = ADDR_W - IDX_W - 2
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic              ent_valid,
    input  logic [TAG_W-1:0]  ent_tag,
    input  logic [ADDR_W-1:0] ent_target,
    input  dir_state_t        ent_state,
    output logic              is_branch,
    output logic              go_taken,
    output logic [ADDR_W-1:0] next_pc
);

    logic [ADDR_W-1:0] seq_pc;

    assign seq_pc = pc + ADDR_W'(4);

    always_comb begin
        is_branch = ent_valid && (ent_tag == pc[ADDR_W-1:IDX_W+2]);
        go_taken  = is_branch && dir_says_taken(ent_state);
        next_pc   = go_taken ? ent_target : seq_pc;
    end

endmodule

// File: rtl/fetch_branch_predictor.sv
module fetch_branch_predictor
    import btbp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              pred_branch,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_next_pc,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);

    localparam int TAG_W = ADDR_W - IDX_W - 2;

    logic [IDX_W-1:0]  fetch_idx;
    logic [IDX_W-1:0]  upd_idx;
    logic [TAG_W-1:0]  upd_tag;
    logic              unused_upd_lsb;

    logic              fa_valid;
    logic [TAG_W-1:0]  fa_tag;
    logic [ADDR_W-1:0] fa_target;
    dir_state_t        fa_state;

    logic              ub_valid;
    logic [TAG_W-1:0]  ub_tag;
    dir_state_t        upd_state_cur;
    dir_state_t        upd_state_nxt;

    logic              upd_hit;
    logic              wr_en;
    dir_state_t        wr_state;

    assign fetch_idx      = fetch_pc[IDX_W+1:2];
    assign upd_idx        = upd_pc[IDX_W+1:2];
    assign upd_tag        = upd_pc[ADDR_W-1:IDX_W+2];
    assign unused_upd_lsb = ^upd_pc[1:0];

    btbp_entry_array #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .fa_idx    (fetch_idx),
        .fa_valid  (fa_valid),
        .fa_tag    (fa_tag),
        .fa_target (fa_target),
        .fa_state  (fa_state),
        .ub_idx    (upd_idx),
        .ub_valid  (ub_valid),
        .ub_tag    (ub_tag),
        .ub_state  (upd_state_cur),
        .wr_en     (wr_en),
        .wr_idx    (upd_idx),
        .wr_tag    (upd_tag),
        .wr_target (upd_target),
        .wr_state  (wr_state)
    );

    btbp_lookup #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W)
    ) u_lookup (
        .pc         (fetch_pc),
        .ent_valid  (fa_valid),
        .ent_tag    (fa_tag),
        .ent_target (fa_target),
        .ent_state  (fa_state),
        .is_branch  (pred_branch),
        .go_taken   (pred_taken),
        .next_pc    (pred_next_pc)
    );

    btbp_dir_counter u_step (
        .cur_state     (upd_state_cur),
        .outcome_taken (upd_taken),
        .next_state    (upd_state_nxt)
    );

    // hit: step counter and rewrite target; taken miss: allocate weakly taken
    always_comb begin
        upd_hit  = ub_valid && (ub_tag == upd_tag);
        wr_en    = upd_valid && (upd_hit || upd_taken);
        wr_state = upd_hit ? upd_state_nxt : CTR_WEAK_T;
    end

endmodule

// File: rtl/fetch_branch_predictor_checker.sv
module fetch_branch_predictor_checker
    import btbp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              pred_branch,
    input logic              pred_taken,
    input logic [ADDR_W-1:0] pred_next_pc,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] upd_pc,
    input logic              upd_taken,
    input logic              upd_hit,
    input dir_state_t        upd_state_cur,
    input dir_state_t        upd_state_nxt
);

    // R2: a non-branch predicts sequential fetch
    a_r2_miss_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_branch |-> (!pred_taken && pred_next_pc == fetch_pc + ADDR_W'(4)));

    // R3: a taken prediction is only made for a known branch
    a_r3_taken_needs_branch: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_branch);

    // R4: saturation at the top
    a_r4_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_hit && upd_taken && upd_state_cur == CTR_STRONG_T)
            |-> upd_state_nxt == CTR_STRONG_T);

    // R4: saturation at the bottom
    a_r4_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_hit && !upd_taken && upd_state_cur == CTR_STRONG_NT)
            |-> upd_state_nxt == CTR_STRONG_NT);

    // R6: a taken update makes its PC a known branch on the next cycle
    a_r6_taken_installs: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |=> (fetch_pc != $past(upd_pc) || pred_branch));

    // R7: a not-taken miss leaves its PC unknown on the next cycle
    a_r7_nt_miss_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && !upd_hit)
            |=> (fetch_pc != $past(upd_pc) || !pred_branch));

endmodule

bind fetch_branch_predictor fetch_branch_predictor_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_pc      (fetch_pc),
    .pred_branch   (pred_branch),
    .pred_taken    (pred_taken),
    .pred_next_pc  (pred_next_pc),
    .upd_valid     (upd_valid),
    .upd_pc        (upd_pc),
    .upd_taken     (upd_taken),
    .upd_hit       (upd_hit),
    .upd_state_cur (upd_state_cur),
    .upd_state_nxt (upd_state_nxt)
);

// File: tb/tb_fetch_branch_predictor.sv
module tb_fetch_branch_predictor;

    localparam int AW    = 32;
    localparam int IW    = 4;
    localparam int DEPTH = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic          pred_branch;
    logic          pred_taken;
    logic [AW-1:0] pred_next_pc;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic          upd_taken = 1'b0;
    logic [AW-1:0] upd_target = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // model of the table
    bit            m_valid [DEPTH];
    logic [AW-7:0] m_tag   [DEPTH];
    logic [AW-1:0] m_tgt   [DEPTH];
    int            m_ctr   [DEPTH];

    always #5 clk = ~clk;

    fetch_branch_predictor #(.ADDR_W(AW), .IDX_W(IW)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_pc     (fetch_pc),
        .pred_branch  (pred_branch),
        .pred_taken   (pred_taken),
        .pred_next_pc (pred_next_pc),
        .upd_valid    (upd_valid),
        .upd_pc       (upd_pc),
        .upd_taken    (upd_taken),
        .upd_target   (upd_target)
    );

    task automatic check(input string req, input string what, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit m_hit(input logic [AW-1:0] pc);
        int i = int'(pc[IW+1:2]);
        return m_valid[i] && (m_tag[i] == pc[AW-1:IW+2]);
    endfunction

    // drive a lookup away from the edge and compare with the model
    task automatic look(input logic [AW-1:0] pc, input string req);
        int i;
        bit h, t;
        @(negedge clk);
        fetch_pc = pc;
        #1;
        i = int'(pc[IW+1:2]);
        h = m_hit(pc);
        t = h && (m_ctr[i] >= 2);
        check(req, "pred_branch", AW'(pred_branch), AW'(h));
        check(req, "pred_taken", AW'(pred_taken), AW'(t));
        check(req, "pred_next_pc", pred_next_pc, t ? m_tgt[i] : pc + 32'd4);
    endtask

    function automatic void m_update(input logic [AW-1:0] pc, input bit tk,
                                     input logic [AW-1:0] tgt);
        int i = int'(pc[IW+1:2]);
        if (m_hit(pc)) begin
            if (tk && m_ctr[i] < 3) m_ctr[i]++;
            if (!tk && m_ctr[i] > 0) m_ctr[i]--;
            m_tgt[i] = tgt;
        end else if (tk) begin
            m_valid[i] = 1'b1;
            m_tag[i]   = pc[AW-1:IW+2];
            m_tgt[i]   = tgt;
            m_ctr[i]   = 2;
        end
    endfunction

    task automatic upd(input logic [AW-1:0] pc, input bit tk, input logic [AW-1:0] tgt);
        @(negedge clk);
        upd_valid  = 1'b1;
        upd_pc     = pc;
        upd_taken  = tk;
        upd_target = tgt;
        @(posedge clk);
        m_update(pc, tk, tgt);
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    function automatic logic [AW-1:0] mkpc(input int tag, input int idx);
        return (AW'(tag) << (IW + 2)) | (AW'(idx) << 2);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] lf;
        logic [AW-1:0] p;
        for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: nothing known after reset
        for (int i = 0; i < DEPTH; i++) look(mkpc(i + 7, i), "R8");

        // R7: not-taken miss does not allocate
        upd(mkpc(3, 5), 1'b0, 32'h1000);
        look(mkpc(3, 5), "R7");

        // R6: taken miss allocates weakly taken
        upd(mkpc(3, 5), 1'b1, 32'h2000);
        look(mkpc(3, 5), "R6");
        check("R6", "alloc taken", AW'(pred_taken), 32'd1);

        // R4: walk the counter to both ends and hold
        upd(mkpc(3, 5), 1'b1, 32'h2000);
        upd(mkpc(3, 5), 1'b1, 32'h2000);
        look(mkpc(3, 5), "R4");
        upd(mkpc(3, 5), 1'b0, 32'h2000);
        look(mkpc(3, 5), "R4");
        check("R4", "still taken from 3->2", AW'(pred_taken), 32'd1);
        upd(mkpc(3, 5), 1'b0, 32'h2000);
        look(mkpc(3, 5), "R4");
        check("R4", "weak nt", AW'(pred_taken), 32'd0);
        upd(mkpc(3, 5), 1'b0, 32'h2000);
        upd(mkpc(3, 5), 1'b0, 32'h2000);
        upd(mkpc(3, 5), 1'b1, 32'h2000);
        look(mkpc(3, 5), "R4");
        check("R4", "low saturation then one up", AW'(pred_taken), 32'd0);
        check("R3", "branch still known", AW'(pred_branch), 32'd1);

        // R5: target rewritten on hit
        upd(mkpc(3, 5), 1'b1, 32'h3330);
        upd(mkpc(3, 5), 1'b1, 32'h4440);
        look(mkpc(3, 5), "R5");
        check("R5", "new target", pred_next_pc, 32'h4440);

        // R1: same index, other tag does not match; R10 low bits ignored
        look(mkpc(4, 5), "R1");
        look(mkpc(3, 5) | 32'd3, "R10");
        check("R10", "unaligned hit", AW'(pred_branch), 32'd1);
        upd(mkpc(3, 6) | 32'd2, 1'b1, 32'h5550);
        look(mkpc(3, 6), "R10");

        // R9: same-cycle update and lookup see old contents
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = mkpc(9, 9); upd_taken = 1'b1; upd_target = 32'h6660;
        fetch_pc = mkpc(9, 9);
        #1;
        check("R9", "old contents in update cycle", AW'(pred_branch), 32'd0);
        @(posedge clk);
        m_update(mkpc(9, 9), 1'b1, 32'h6660);
        @(negedge clk);
        upd_valid = 1'b0;
        #1;
        check("R9", "visible next cycle", AW'(pred_branch), 32'd1);

        // R2/R3 sweep: pseudo-random stream on a small aliasing pool
        lf = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            p = mkpc(int'(lf[5:4]), int'(lf[3:0]));
            upd(p, lf[6] | lf[7], {16'h0, lf[15:8], 8'h0} | 32'h100);
            look(p, "R3");
            look(mkpc(int'(lf[9:8]), int'(lf[13:10])), "R2");
        end

        // R8: reset again wipes the table
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) m_valid[i] = 1'b0;
        for (int i = 0; i < DEPTH; i++) look(mkpc(i % 4, i), "R8");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule